// File: doc/BRIEF.md
# Top-Swap Boot-Block Address Inverter

This block sits on the path from the processor to the boot ROM. In normal operation it passes every ROM address through unchanged. When top-swap mode is on, it flips the one address line just above the boot block. The topmost boot block and the backup copy directly below it then trade places, so the reset-vector fetch after a reboot runs from the backup block. Firmware uses this to update the primary boot block without risk of failure.

The swap control bit is kept in the always-powered RTC domain. A normal platform reset does not clear it; only an RTC-domain reset does. A set-only lock-down bit in the general control register freezes both the swap bit and a two-bit boot-strap field until the next platform reset. The swap state can be read back as a read-only status bit in the BIOS control image.

The address translation is combinational. Register writes take effect at the clock edge that samples them.

Top module: `ts_rom_addr_swap`

## Requirements
- R1: When swap is on and the address is in the ROM window, exactly one address bit is inverted: bit 16 + the effective size code. All other bits are unchanged.
- R2: Size code `blk_size` 0,1,2,3,4 selects 64 KB, 128 KB, 256 KB, 512 KB or 1 MB, which invert A16, A17, A18, A19 or A20. Codes 5 to 7 behave as code 4.
- R3: With size code 0 and swap on, address 0xFFFFFFF0 is presented to the ROM as 0xFFFEFFF0.
- R4: An address whose bits 31:24 are not all ones passes through unchanged. Any address passes through unchanged when swap is off.
- R5: The swap bit is bit 0 of the backed-up control register (`reg_sel`=1). It is not cleared by `plat_rst_n` and is cleared only by `rtc_rst_n`.
- R6: The lock bit is bit 0 of the general control register (`reg_sel`=0). Writing 1 sets it, writing 0 does not clear it, and `plat_rst_n` clears it.
- R7: While the lock bit is set, writes to the swap bit and to the strap field are ignored.
- R8: The strap field occupies bits 11:10 of the general control register. While unlocked, it takes the written value and reads back at the same position. All other readback bits are 0.
- R9: `bios_ctl_rd` bit 4 mirrors the swap bit, and all other bits of `bios_ctl_rd` read 0. `ts_status` equals the same bit.
- R10: After both resets, lock, strap and swap all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| plat_rst_n | input | 1 | Platform reset, active low; clears lock and strap |
| rtc_rst_n | input | 1 | RTC-domain reset, active low; clears swap bit |
| cpu_addr | input | 32 | Processor ROM address |
| blk_size | input | 3 | Boot-block size code |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = general control, 1 = backed-up control |
| reg_wdata | input | 32 | Register write data |
| rom_addr | output | 32 | Translated ROM address |
| ts_status | output | 1 | Swap currently active |
| gen_ctl_rd | output | 32 | General control readback (lock, strap) |
| bios_ctl_rd | output | 8 | BIOS control readback with swap status |

## Verification
The translated address depends on inputs with no register in between. The bench therefore applies each address and size, waits 1 ns for it to settle, and compares the result with the inversion mask it computes itself.

Register writes are driven for one full cycle starting at a falling edge. Their effect on the readback, the status and the translation is sampled at the next falling edge, which is half a cycle after the capturing edge. Reset effects are sampled in the same way, after the reset is released.

// File: rtl/ts_swap_pkg.sv
package ts_swap_pkg;
   typedef enum logic {
      SEL_GEN_CTL  = 1'b0,
      SEL_BKUP_CTL = 1'b1
   } ts_reg_sel_e;

   localparam int LOCK_BIT   = 0;
   localparam int STRAP_LSB  = 10;
   localparam int SWAP_BIT   = 0;
   localparam int STATUS_BIT = 4;
endpackage

// File: rtl/ts_swap_ctl.sv
module ts_swap_ctl
   import ts_swap_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int STRAP_W = 2
) (
   input  logic               clk,
   input  logic               plat_rst_n,
   input  logic               rtc_rst_n,
   input  logic               wr_en,
   input  ts_reg_sel_e        wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               lock_q,
   output logic [STRAP_W-1:0] strap_q,
   output logic               swap_q
);
   if (STRAP_LSB + STRAP_W > DATA_W) begin : g_bad_strap
      $error("strap field does not fit in register width");
   end

   logic gen_wr, bkup_wr;
   assign gen_wr  = wr_en && (wr_sel == SEL_GEN_CTL);
   assign bkup_wr = wr_en && (wr_sel == SEL_BKUP_CTL);

   // platform domain: lock (set-only) and strap
   always_ff @(posedge clk or negedge plat_rst_n) begin
      if (!plat_rst_n) begin
         lock_q  <= 1'b0;
         strap_q <= '0;
      end else if (gen_wr) begin
         if (wr_data[LOCK_BIT]) lock_q <= 1'b1;
         if (!lock_q) strap_q <= wr_data[STRAP_LSB +: STRAP_W];
      end
   end

   // RTC domain: swap bit survives platform reset
   always_ff @(posedge clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n) begin
         swap_q <= 1'b0;
      end else if (bkup_wr && !lock_q) begin
         swap_q <= wr_data[SWAP_BIT];
      end
   end

   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!plat_rst_n)
      lock_q |=> lock_q); // R6
   AST_SWAP_FROZEN: assert property (@(posedge clk) disable iff (!plat_rst_n || !rtc_rst_n)
      lock_q |=> $stable(swap_q)); // R7
   AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!plat_rst_n)
      lock_q |=> $stable(strap_q)); // R7
endmodule

// File: rtl/ts_addr_xlate.sv
module ts_addr_xlate #(
   parameter int ADDR_W       = 32,
   parameter int WIN_LOG2     = 24,
   parameter int MIN_BLK_LOG2 = 16,
   parameter int N_SIZES      = 5,
   parameter int SIZE_W       = 3
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              swap_en,
   input  logic [SIZE_W-1:0] size_code,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int MAX_CODE = N_SIZES - 1;

   if (MIN_BLK_LOG2 + N_SIZES > WIN_LOG2) begin : g_bad_win
      $error("inverted lines must lie inside the ROM window");
   end
   if ((1 << SIZE_W) < N_SIZES) begin : g_bad_size_w
      $error("size code too narrow for size count");
   end
   if (WIN_LOG2 >= ADDR_W) begin : g_bad_addr_w
      $error("ROM window must be smaller than address space");
   end

   logic [SIZE_W-1:0]  eff_code;
   logic [N_SIZES-1:0] line_sel;
   logic [ADDR_W-1:0]  flip_mask;
   logic               in_win;

   // reserved codes above the largest size clamp to it
   assign eff_code = (size_code > SIZE_W'(MAX_CODE)) ? SIZE_W'(MAX_CODE) : size_code;

   for (genvar g = 0; g < N_SIZES; g++) begin : g_line
      assign line_sel[g] = (eff_code == SIZE_W'(g));
   end

   always_comb begin
      flip_mask = '0;
      flip_mask[MIN_BLK_LOG2 +: N_SIZES] = line_sel;
   end

   assign in_win   = &addr_in[ADDR_W-1:WIN_LOG2];
   assign addr_out = (swap_en && in_win) ? (addr_in ^ flip_mask) : addr_in;
endmodule

// File: rtl/ts_rom_addr_swap.sv
module ts_rom_addr_swap
   import ts_swap_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter int WIN_LOG2     = 24,
   parameter int MIN_BLK_LOG2 = 16,
   parameter int N_SIZES      = 5,
   parameter int SIZE_W       = 3,
   parameter int STRAP_W      = 2,
   parameter int BCTL_W       = 8
) (
   input  logic              clk,
   input  logic              plat_rst_n,
   input  logic              rtc_rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [SIZE_W-1:0] blk_size,
   input  logic              reg_wr_en,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] rom_addr,
   output logic              ts_status,
   output logic [DATA_W-1:0] gen_ctl_rd,
   output logic [BCTL_W-1:0] bios_ctl_rd
);
   localparam logic [ADDR_W-1:0] FLIP_FIELD =
      ADDR_W'(((64'd1 << N_SIZES) - 64'd1) << MIN_BLK_LOG2);

   if (STATUS_BIT >= BCTL_W) begin : g_bad_bctl
      $error("status bit outside BIOS control width");
   end

   logic               lock_q, swap_q;
   logic [STRAP_W-1:0] strap_q;

   ts_swap_ctl #(.DATA_W(DATA_W), .STRAP_W(STRAP_W)) u_ctl (
      .clk        (clk),
      .plat_rst_n (plat_rst_n),
      .rtc_rst_n  (rtc_rst_n),
      .wr_en      (reg_wr_en),
      .wr_sel     (ts_reg_sel_e'(reg_sel)),
      .wr_data    (reg_wdata),
      .lock_q     (lock_q),
      .strap_q    (strap_q),
      .swap_q     (swap_q)
   );

   ts_addr_xlate #(
      .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .MIN_BLK_LOG2(MIN_BLK_LOG2),
      .N_SIZES(N_SIZES), .SIZE_W(SIZE_W)
   ) u_xlate (
      .addr_in   (cpu_addr),
      .swap_en   (swap_q),
      .size_code (blk_size),
      .addr_out  (rom_addr)
   );

   always_comb begin
      gen_ctl_rd = '0;
      gen_ctl_rd[LOCK_BIT] = lock_q;
      gen_ctl_rd[STRAP_LSB +: STRAP_W] = strap_q;
      bios_ctl_rd = '0;
      bios_ctl_rd[STATUS_BIT] = swap_q;
   end
   assign ts_status = swap_q;

   AST_PASS_OUTSIDE_WIN: assert property (@(posedge clk) disable iff (!plat_rst_n || !rtc_rst_n)
      !(&cpu_addr[ADDR_W-1:WIN_LOG2]) |-> (rom_addr == cpu_addr)); // R4
   AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!plat_rst_n || !rtc_rst_n)
      !ts_status |-> (rom_addr == cpu_addr)); // R4
   AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!plat_rst_n || !rtc_rst_n)
      ts_status && (&cpu_addr[ADDR_W-1:WIN_LOG2]) |-> ($countones(rom_addr ^ cpu_addr) == 1)); // R1
   AST_FLIP_IN_FIELD: assert property (@(posedge clk) disable iff (!plat_rst_n || !rtc_rst_n)
      ((rom_addr ^ cpu_addr) & ~FLIP_FIELD) == '0); // R2
endmodule

// File: tb/ts_rom_addr_swap_tb.sv
module ts_rom_addr_swap_tb;
   logic        clk = 1'b0;
   logic        plat_rst_n = 1'b0;
   logic        rtc_rst_n = 1'b0;
   logic [31:0] cpu_addr = 32'h0;
   logic [2:0]  blk_size = 3'd0;
   logic        reg_wr_en = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] rom_addr;
   logic        ts_status;
   logic [31:0] gen_ctl_rd;
   logic [7:0]  bios_ctl_rd;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ts_rom_addr_swap u_dut (
      .clk(clk), .plat_rst_n(plat_rst_n), .rtc_rst_n(rtc_rst_n),
      .cpu_addr(cpu_addr), .blk_size(blk_size), .reg_wr_en(reg_wr_en),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rom_addr(rom_addr),
      .ts_status(ts_status), .gen_ctl_rd(gen_ctl_rd), .bios_ctl_rd(bios_ctl_rd)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic sel, logic [31:0] data);
      @(negedge clk);
      reg_sel = sel; reg_wdata = data; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   function automatic logic [31:0] exp_addr(logic [31:0] a, logic sw, logic [2:0] sz);
      int eff = (sz > 3'd4) ? 4 : int'(sz);
      if (sw && a[31:24] == 8'hFF) return a ^ (32'h1 << (16 + eff));
      return a;
   endfunction

   task automatic sweep(logic sw);
      logic [31:0] pats [8] = '{32'hFFFF_FFF0, 32'hFF00_0000, 32'hFFF1_2345,
                                32'hFFE0_0000, 32'h00FF_FFF0, 32'hFEFF_FFFF,
                                32'h7FFF_FFF0, 32'hFFFE_FFF0};
      for (int s = 0; s < 8; s++) begin
         for (int p = 0; p < 8; p++) begin
            blk_size = 3'(s); cpu_addr = pats[p];
            #1;
            if (pats[p][31:24] != 8'hFF || !sw)
               chk("R4 pass-through", rom_addr, exp_addr(pats[p], sw, 3'(s)));
            else if (s > 4)
               chk("R2 reserved size code", rom_addr, exp_addr(pats[p], sw, 3'(s)));
            else
               chk("R1/R2 single line inversion", rom_addr, exp_addr(pats[p], sw, 3'(s)));
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      plat_rst_n = 1'b1; rtc_rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 general control after reset", gen_ctl_rd, 32'h0);
      chk("R10 bios control after reset", {24'h0, bios_ctl_rd}, 32'h0);
      chk("R10 status after reset", {31'h0, ts_status}, 32'h0);

      sweep(1'b0);                                   // R4 swap off
      wr(1'b1, 32'h1);                               // R5 set swap
      chk("R5 swap set", {31'h0, ts_status}, 32'h1);
      chk("R9 status mirror bit 4", {24'h0, bios_ctl_rd}, 32'h10);
      sweep(1'b1);                                   // R1 R2 R4
      blk_size = 3'd0; cpu_addr = 32'hFFFF_FFF0; #1;
      chk("R3 reset vector to backup block", rom_addr, 32'hFFFE_FFF0);

      wr(1'b0, 32'h0000_0800);                       // R8 strap=2
      chk("R8 strap readback", gen_ctl_rd, 32'h0000_0800);
      wr(1'b0, 32'h0000_0C01);                       // lock + strap=3 (unlocked this cycle)
      chk("R6 lock set", gen_ctl_rd, 32'h0000_0C01);
      wr(1'b0, 32'h0000_0000);
      chk("R6 lock not cleared by write 0", gen_ctl_rd[0], 32'h1);
      chk("R7 strap frozen while locked", gen_ctl_rd, 32'h0000_0C01);
      wr(1'b1, 32'h0);
      chk("R7 swap write ignored while locked", {31'h0, ts_status}, 32'h1);
      cpu_addr = 32'hFFFF_FFF0; blk_size = 3'd0; #1;
      chk("R7 translation still active", rom_addr, 32'hFFFE_FFF0);

      // platform reset: lock/strap clear, swap survives
      @(negedge clk); plat_rst_n = 1'b0;
      @(negedge clk); @(negedge clk); plat_rst_n = 1'b1;
      @(negedge clk);
      chk("R6 lock cleared by platform reset", gen_ctl_rd, 32'h0);
      chk("R5 swap survives platform reset", {31'h0, ts_status}, 32'h1);
      chk("R9 status after platform reset", {24'h0, bios_ctl_rd}, 32'h10);

      wr(1'b1, 32'h0);
      chk("R7 swap writable after unlock", {31'h0, ts_status}, 32'h0);
      wr(1'b1, 32'h1);
      // RTC reset clears swap
      @(negedge clk); rtc_rst_n = 1'b0;
      @(negedge clk); rtc_rst_n = 1'b1;
      @(negedge clk);
      chk("R5 swap cleared by rtc reset", {31'h0, ts_status}, 32'h0);
      cpu_addr = 32'hFFFF_FFF0; #1;
      chk("R5 pass-through after rtc reset", rom_addr, 32'hFFFF_FFF0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule